// File: doc/BRIEF.md
# H-Bridge Gate Sequencer With Deadtime

This block produces the four gate commands of one H-bridge: a high-side and a low-side switch on each of two legs, leg 0 and leg 1. A phase bit chooses the current polarity. A PWM request marks the on time and the off time. A decay select chooses how the winding current recirculates while the request is low. The block puts a programmable number of clock cycles between turning one switch of a leg off and turning the other switch of that leg on. The bridge enable and the system enable turn every gate off in the same cycle they go low.

The sequencer is a six-state machine, all gates being zero unless the state says otherwise. `ST_IDLE` holds the bridge off while either enable is low. `ST_BLANK` holds all gates off for the deadtime and waits there for a PWM request. `ST_DRIVE` applies the on pair. `ST_DECAY_GAP` is the deadtime at the start of an off time. `ST_RECIRC` applies synchronous rectification. `ST_RESUME_GAP` is the deadtime before the on pair returns. Transitions:
- IDLE→BLANK when both enables are high.
- BLANK→DRIVE when the gap has expired and the PWM request is high.
- DRIVE→DECAY_GAP when the request falls. The decay select is latched here.
- DECAY_GAP→RECIRC when the gap expires with the request low. DECAY_GAP→DRIVE when it expires with the request high.
- RECIRC→RESUME_GAP when the request rises.
- RESUME_GAP→DRIVE when the gap expires with the request high. RESUME_GAP→RECIRC when it expires with the request low.
- DRIVE, DECAY_GAP, RECIRC or RESUME_GAP→BLANK when the phase bit differs from the latched polarity.
- Any state→IDLE when either enable is low.

The "source leg" is the leg whose high side conducts during the on time. It is leg 0 when the latched phase is 1 and leg 1 when it is 0.

Top module: `hbg_sequencer`

## Requirements
- R1: While reset is asserted, all four gate outputs are 0.
- R2: In the on state with phase 1, `hs_gate[0]` and `ls_gate[1]` are 1 and the other two gates are 0. With phase 0, `hs_gate[1]` and `ls_gate[0]` are 1 and the other two are 0. After both enables go high, the on state is reached once DEAD_CYC all-off cycles have passed and the PWM request is high.
- R3: The high gate and the low gate of the same leg are never 1 together.
- R4: A gate turns on only after the other gate of its leg has been off for at least DEAD_CYC consecutive clock cycles.
- R5: Fast decay (`slow_decay`=0 when the request falls): all gates are 0 for DEAD_CYC cycles. After that, only the low gate of the source leg is 1.
- R6: Slow decay (`slow_decay`=1 when the request falls): only the high gate of the source leg is 1 for DEAD_CYC cycles. After that, both high gates are 1 and both low gates are 0.
- R7: When the request rises during recirculation, the recirculation-only gates turn off. That leaves all gates off in fast decay and only the source high gate on in slow decay, for DEAD_CYC cycles. The on pattern then returns.
- R8: The decay select is sampled only when the request falls. A change of `slow_decay` during the off time does not change the gate outputs.
- R9: A change of the phase bit while the bridge is active turns all gates off for DEAD_CYC cycles. The on pattern of the new polarity follows if the request is high. If the request is low, the gates stay off until it rises, and the new on pattern appears one cycle later.
- R10: When `sys_en` or `bridge_en` is low, all four gates are 0 in that same cycle, without waiting for a clock edge. After the enables return, the gates stay off for at least DEAD_CYC cycles.
- R11: If the request rises again during the deadtime at the start of an off time, that deadtime still runs to its end. The on pattern then returns directly, without recirculation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_en | input | 1 | Global enable; low forces all gates off |
| bridge_en | input | 1 | Enable of this bridge; low forces all gates off |
| phase | input | 1 | Polarity: 1 conducts leg 0 high to leg 1 low |
| pwm_on | input | 1 | 1 requests the on time, 0 the off time |
| slow_decay | input | 1 | Off-time mode: 1 slow decay, 0 fast decay |
| hs_gate | output | 2 | High-side gate commands, index = leg |
| ls_gate | output | 2 | Low-side gate commands, index = leg |

## Verification
The gates are decoded combinationally from the registered state. An input change made on a falling edge therefore takes effect at the next rising edge. Any deadtime that change starts shows on the next DEAD_CYC falling-edge samples, and the following pattern appears on the sample after them. An enable drop is the exception: it clears the gates at once, so the bench looks at them one time step after driving it. The directed checks sample each deadtime cycle and the first cycle after it. The random phase checks leg exclusion, the per-leg off-count before each gate rises, and the effect of the enables on every cycle.

// File: rtl/hbg_pkg.sv
`timescale 1ns/1ps
package hbg_pkg;
    localparam int LEGS = 2;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_BLANK      = 3'd1,
        ST_DRIVE      = 3'd2,
        ST_DECAY_GAP  = 3'd3,
        ST_RECIRC     = 3'd4,
        ST_RESUME_GAP = 3'd5
    } hbg_state_e;
endpackage

// File: rtl/hbg_gap_timer.sv
`timescale 1ns/1ps
module hbg_gap_timer #(
    parameter int DEAD_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);
    localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // R4: a load always restarts the full window
    a_r4_reload_full: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == RELOAD));
endmodule

// File: rtl/hbg_gate_map.sv
`timescale 1ns/1ps
module hbg_gate_map
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  hbg_state_e      st,
    input  logic            phase_q,
    input  logic            slow_q,
    input  logic            en_ok,
    output logic [LEGS-1:0] hs,
    output logic [LEGS-1:0] ls
);
    localparam int OCW = $clog2(DEAD_CYC + 1);
    localparam logic [OCW-1:0] SAT = OCW'(DEAD_CYC);

    for (genvar i = 0; i < LEGS; i++) begin : g_leg
        logic is_src;
        logic hi_raw;
        logic lo_raw;

        assign is_src = (i == 0) ? phase_q : !phase_q;

        always_comb begin
            hi_raw = 1'b0;
            lo_raw = 1'b0;
            unique case (st)
                ST_DRIVE: begin
                    hi_raw = is_src;
                    lo_raw = !is_src;
                end
                ST_DECAY_GAP, ST_RESUME_GAP: begin
                    hi_raw = slow_q & is_src;
                end
                ST_RECIRC: begin
                    hi_raw = slow_q;
                    lo_raw = !slow_q & is_src;
                end
                default: begin
                    hi_raw = 1'b0;
                    lo_raw = 1'b0;
                end
            endcase
        end

        assign hs[i] = hi_raw & en_ok;
        assign ls[i] = lo_raw & en_ok;

        // Off-time counters of this leg, saturating at the deadtime
        logic [OCW-1:0] hi_off_q;
        logic [OCW-1:0] lo_off_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_off_q <= '0;
                lo_off_q <= '0;
            end else begin
                hi_off_q <= hs[i] ? '0 : ((hi_off_q == SAT) ? hi_off_q : hi_off_q + 1'b1);
                lo_off_q <= ls[i] ? '0 : ((lo_off_q == SAT) ? lo_off_q : lo_off_q + 1'b1);
            end
        end

        // R3: legs never shoot through
        a_r3_leg_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(hs[i] && ls[i]));

        // R4: a high gate rises only after its low partner sat off for the deadtime
        a_r4_hi_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hs[i]) |-> (lo_off_q == SAT));

        // R4: a low gate rises only after its high partner sat off for the deadtime
        a_r4_lo_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ls[i]) |-> (hi_off_q == SAT));
    end
endmodule

// File: rtl/hbg_sequencer.sv
`timescale 1ns/1ps
module hbg_sequencer
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sys_en,
    input  logic       bridge_en,
    input  logic       phase,
    input  logic       pwm_on,
    input  logic       slow_decay,
    output logic [1:0] hs_gate,
    output logic [1:0] ls_gate
);
    hbg_state_e st_q;
    hbg_state_e st_d;
    logic       phase_q;
    logic       slow_q;
    logic       gap_load;
    logic       gap_done;
    logic       en_ok;
    logic       flip;

    assign en_ok = sys_en & bridge_en;
    assign flip  = (phase != phase_q);

    // Next-state and gap-timer load
    always_comb begin
        st_d     = st_q;
        gap_load = 1'b0;
        if (!en_ok) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d     = ST_BLANK;
                    gap_load = 1'b1;
                end
                ST_BLANK: begin
                    if (gap_done && pwm_on) st_d = ST_DRIVE;
                end
                ST_DRIVE: begin
                    if (flip) begin
                        st_d     = ST_BLANK;
                        gap_load = 1'b1;
                    end else if (!pwm_on) begin
                        st_d     = ST_DECAY_GAP;
                        gap_load = 1'b1;
                    end
                end
                ST_DECAY_GAP: begin
                    if (flip) begin
                        st_d     = ST_BLANK;
                        gap_load = 1'b1;
                    end else if (gap_done) begin
                        st_d = pwm_on ? ST_DRIVE : ST_RECIRC;
                    end
                end
                ST_RECIRC: begin
                    if (flip) begin
                        st_d     = ST_BLANK;
                        gap_load = 1'b1;
                    end else if (pwm_on) begin
                        st_d     = ST_RESUME_GAP;
                        gap_load = 1'b1;
                    end
                end
                ST_RESUME_GAP: begin
                    if (flip) begin
                        st_d     = ST_BLANK;
                        gap_load = 1'b1;
                    end else if (gap_done) begin
                        st_d = pwm_on ? ST_DRIVE : ST_RECIRC;
                    end
                end
                default: begin
                    st_d = ST_IDLE;
                end
            endcase
        end
    end

    // State register with polarity and decay latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            phase_q <= 1'b0;
            slow_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE || st_q == ST_BLANK) begin
                phase_q <= phase;
            end
            if (st_q == ST_DRIVE && st_d == ST_DECAY_GAP) begin
                slow_q <= slow_decay;
            end
        end
    end

    hbg_gap_timer #(.DEAD_CYC(DEAD_CYC)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gap_load),
        .done  (gap_done)
    );

    // Output decode
    hbg_gate_map #(.DEAD_CYC(DEAD_CYC)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .st      (st_q),
        .phase_q (phase_q),
        .slow_q  (slow_q),
        .en_ok   (en_ok),
        .hs      (hs_gate),
        .ls      (ls_gate)
    );

    // R10: a dropped enable parks the machine in idle
    a_r10_enable_park: assert property (@(posedge clk) disable iff (!rst_n)
        !en_ok |=> (st_q == ST_IDLE));

    // R2: the on state is only entered from an expired gap
    a_r2_drive_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DRIVE && $past(st_q) != ST_DRIVE) |-> $past(gap_done));

    // R8: decay choice held throughout recirculation
    a_r8_decay_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RECIRC && $past(st_q) == ST_RECIRC) |-> $stable(slow_q));
endmodule

// File: tb/tb_hbg_sequencer.sv
`timescale 1ns/1ps
module tb_hbg_sequencer;
    localparam int N = 4;

    localparam int K_OFF  = 0;
    localparam int K_DRV  = 1;
    localparam int K_FRC  = 2;
    localparam int K_SHLD = 3;
    localparam int K_SRC  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_en = 1'b1;
    logic       bridge_en = 1'b1;
    logic       phase = 1'b1;
    logic       pwm_on = 1'b1;
    logic       slow_decay = 1'b0;
    logic [1:0] hs_gate;
    logic [1:0] ls_gate;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hbg_sequencer #(.DEAD_CYC(N)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_en     (sys_en),
        .bridge_en  (bridge_en),
        .phase      (phase),
        .pwm_on     (pwm_on),
        .slow_decay (slow_decay),
        .hs_gate    (hs_gate),
        .ls_gate    (ls_gate)
    );

    // Pattern order {hs1, hs0, ls1, ls0}; source leg is 0 for phase 1
    function automatic logic [3:0] pat(input logic ph, input int kind);
        logic [1:0] h;
        logic [1:0] l;
        logic [1:0] src;
        src = ph ? 2'b01 : 2'b10;
        h = 2'b00;
        l = 2'b00;
        case (kind)
            K_DRV:  begin h = src; l = ~src; end
            K_FRC:  l = src;
            K_SHLD: h = src;
            K_SRC:  h = 2'b11;
            default: ;
        endcase
        return {h[1], h[0], l[1], l[0]};
    endfunction

    function automatic logic [3:0] now_pat();
        return {hs_gate[1], hs_gate[0], ls_gate[1], ls_gate[0]};
    endfunction

    task automatic chk(input logic [3:0] exp, input string tag);
        total++;
        if (now_pat() !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, now_pat(), exp, $time);
        end
    endtask

    // Sample the deadtime window and the pattern that follows it
    task automatic window(input logic [3:0] gap_p, input logic [3:0] fin_p, input string tag);
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            chk(gap_p, tag);
        end
        @(negedge clk);
        chk(fin_p, tag);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] p;
        logic [3:0] prv;
        int hoff [2];
        int loff [2];
        void'($urandom(32'd5213));

        // R1 reset
        repeat (3) @(negedge clk);
        chk(4'b0000, "R1 reset gates off");

        rst_n = 1'b1;
        window(pat(1, K_OFF), pat(1, K_DRV), "R2 first drive phase1");

        // R5 fast decay
        pwm_on = 1'b0; slow_decay = 1'b0;
        window(pat(1, K_OFF), pat(1, K_FRC), "R5 fast decay");
        // R8 decay select ignored mid off time
        slow_decay = 1'b1;
        repeat (3) @(negedge clk);
        chk(pat(1, K_FRC), "R8 fast held");
        // R7 return from fast
        pwm_on = 1'b1;
        window(pat(1, K_OFF), pat(1, K_DRV), "R7 resume fast");

        // R6 slow decay
        pwm_on = 1'b0; slow_decay = 1'b1;
        window(pat(1, K_SHLD), pat(1, K_SRC), "R6 slow decay");
        slow_decay = 1'b0;
        repeat (3) @(negedge clk);
        chk(pat(1, K_SRC), "R8 slow held");
        pwm_on = 1'b1;
        window(pat(1, K_SHLD), pat(1, K_DRV), "R7 resume slow");

        // R9 phase change while driving
        phase = 1'b0;
        window(pat(0, K_OFF), pat(0, K_DRV), "R9 phase flip drive");

        // R10 system enable
        sys_en = 1'b0;
        #1;
        chk(4'b0000, "R10 sys_en immediate off");
        repeat (3) begin
            @(negedge clk);
            chk(4'b0000, "R10 sys_en held off");
        end
        sys_en = 1'b1;
        window(pat(0, K_OFF), pat(0, K_DRV), "R10 sys_en return");

        // R10 bridge enable
        bridge_en = 1'b0;
        #1;
        chk(4'b0000, "R10 bridge_en immediate off");
        @(negedge clk);
        bridge_en = 1'b1;
        window(pat(0, K_OFF), pat(0, K_DRV), "R10 bridge_en return");

        // R11 request returns inside the decay gap
        pwm_on = 1'b0; slow_decay = 1'b0;
        @(negedge clk); chk(4'b0000, "R11 gap");
        @(negedge clk); chk(4'b0000, "R11 gap");
        pwm_on = 1'b1;
        for (int k = 2; k < N; k++) begin
            @(negedge clk);
            chk(4'b0000, "R11 gap completes");
        end
        @(negedge clk);
        chk(pat(0, K_DRV), "R11 direct resume");

        // R9 phase change during recirculation with request low
        pwm_on = 1'b0;
        window(pat(0, K_OFF), pat(0, K_FRC), "R5 fast decay phase0");
        phase = 1'b1;
        for (int k = 0; k < N + 2; k++) begin
            @(negedge clk);
            chk(4'b0000, "R9 flip waits off");
        end
        pwm_on = 1'b1;
        @(negedge clk);
        chk(pat(1, K_DRV), "R9 new polarity");

        // Random phase: invariants on every cycle
        prv = now_pat();
        for (int i = 0; i < 2; i++) begin hoff[i] = N; loff[i] = N; end
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            p = now_pat();
            for (int i = 0; i < 2; i++) begin
                total++;
                if (p[2 + i] && p[i]) begin
                    bad++;
                    $display("FAIL R3 leg %0d: got %b expected exclusive", i, p);
                end
                if (p[2 + i] && !prv[2 + i]) begin
                    total++;
                    if (loff[i] < N) begin
                        bad++;
                        $display("FAIL R4 hs%0d rise: got gap %0d expected %0d", i, loff[i], N);
                    end
                end
                if (p[i] && !prv[i]) begin
                    total++;
                    if (hoff[i] < N) begin
                        bad++;
                        $display("FAIL R4 ls%0d rise: got gap %0d expected %0d", i, hoff[i], N);
                    end
                end
                hoff[i] = p[2 + i] ? 0 : ((hoff[i] < N) ? hoff[i] + 1 : N);
                loff[i] = p[i] ? 0 : ((loff[i] < N) ? loff[i] + 1 : N);
            end
            if (!(sys_en && bridge_en)) chk(4'b0000, "R10 random enable low");
            prv = p;
            sys_en     = ($urandom_range(15) != 0);
            bridge_en  = ($urandom_range(15) != 0);
            if ($urandom_range(7) == 0) pwm_on = ~pwm_on;
            if ($urandom_range(31) == 0) phase = ~phase;
            slow_decay = $urandom_range(1);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule